// File: doc/BRIEF.md
# Disk Read Word Synchronizer

This block sits behind the data separator of a disk read channel. It takes the recovered serial stream one bit per strobe and frames it into 16-bit words for the transfer engine. A programmable sync register holds the pattern it looks for. When that pattern appears, the word framing snaps to the bit that follows it. A gating mode holds back all data until the first match. A byte mode frames each 8-bit disk byte on a leading 1 bit, for group-coded recordings whose bytes always carry a set top bit. Two sticky flags report a sync match and the end of a block of a programmed word count.

A read starts on the rising edge of the read enable. At that edge the framing clears and the word count loads. Each delivered word appears on the word output with a one-cycle valid strobe.

Top module: `disk_word_sync`

## Requirements
- R1: After reset the word valid strobe and both flags are low, and the sync register holds 16'h4489.
- R2: On every accepted bit strobe the bit enters a 16-bit shift register at the LSB side. The shifted value is compared with the sync register once at least 16 bits have entered since read start. Overlapping occurrences each count as a match.
- R3: The sync flag is set on every match, whether gating is on or off. It stays set until sync_clr_i is pulsed, and a match in the same cycle wins over the clear.
- R4: With gating enabled at read start, no word is delivered before the first match. The sync pattern itself is never delivered, and the first word delivered is the next full 16 bits after it.
- R5: Every match resets the word framing, also after delivery has begun. Framing then restarts with the following bit.
- R6: With gating disabled, a word (first received bit in bit 15) is delivered after every 16th accepted bit counted from read start.
- R7: In byte mode (msb_mode_i=1), a byte starts with a 1 bit seen while hunting and closes 7 bits later. Two bytes are packed into one word, with the first byte in bits 15:8.
- R8: word_o is valid only during a one-cycle word_valid_o pulse, in the cycle after the bit strobe that completes the word.
- R9: word_count_i is loaded at read start and decremented only by delivered words. Delivery stops at zero. The block flag is set together with the strobe of the last word and stays set until blk_clr_i is pulsed.
- R10: A pulse on sync_we_i loads sync_wdata_i into the sync register, and later comparisons use the new value.
- R11: Bit strobes while read_en_i is low, or in the cycle read_en_i rises, are ignored. They set no flag and deliver no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| read_en_i | input | 1 | Read in progress; rising edge starts a read |
| gate_en_i | input | 1 | Hold data until first sync match (sampled at read start) |
| msb_mode_i | input | 1 | Byte framing on a leading 1 bit |
| bit_i | input | 1 | Serial data bit |
| bit_en_i | input | 1 | Bit strobe |
| sync_we_i | input | 1 | Sync register write |
| sync_wdata_i | input | 16 | Sync register write data |
| word_count_i | input | 16 | Words to transfer, loaded at read start |
| sync_clr_i | input | 1 | Clear sync flag |
| blk_clr_i | input | 1 | Clear block flag |
| word_o | output | 16 | Delivered word |
| word_valid_o | output | 1 | One-cycle word strobe |
| sync_irq_o | output | 1 | Sticky sync-match flag |
| blk_irq_o | output | 1 | Sticky block-complete flag |

## Verification
The assertions assume that a strobe completing a word is never followed by another word-completing strobe on the next cycle. This holds because any word needs 16 bits. They also assume that clears and bits do not collide with a sync write. The bench sends at most one bit per two cycles with random idle gaps. It issues clears and sync writes only while no bit strobe is pending, and it holds the mode inputs steady through each read.

// File: rtl/dws_pkg.sv
package dws_pkg;
    // One accepted bit event handed from the matcher side to the framer
    typedef struct packed {
        logic step;
        logic bit_val;
        logic match;
    } dws_bit_t;
endpackage

// File: rtl/dws_matcher.sv
module dws_matcher #(
    parameter int              W        = 16,
    parameter logic [W-1:0]    SYNC_RST = 16'h4489
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         step,
    input  logic         bit_i,
    input  logic         sync_we,
    input  logic [W-1:0] sync_wdata,
    output logic [W-1:0] sh_next,
    output logic         match
);
    localparam int FW = $clog2(W + 1);
    localparam logic [FW-1:0] FILL_FULL = FW'(W);
    localparam logic [FW-1:0] FILL_ARM  = FW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [FW-1:0] fill;
        logic [W-1:0]  sync;
    } mst_t;

    mst_t q, d;

    always_comb begin
        d       = q;
        sh_next = {q.sh[W-2:0], bit_i};
        match   = step && !restart && (q.fill >= FILL_ARM) && (sh_next == q.sync);
        if (sync_we) begin
            d.sync = sync_wdata;
        end
        if (restart) begin
            d.sh   = '0;
            d.fill = '0;
        end else if (step) begin
            d.sh = sh_next;
            if (q.fill != FILL_FULL) begin
                d.fill = q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sh: '0, fill: '0, sync: SYNC_RST};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dws_framer.sv
module dws_framer
    import dws_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          gate_en,
    input  logic          msb_mode,
    input  logic [CW-1:0] count_load,
    input  dws_bit_t      ev,
    input  logic [W-1:0]  sh_next,
    output logic [W-1:0]  word_o,
    output logic          valid_o,
    output logic          blk_done
);
    localparam int H    = W / 2;
    localparam int CNTW = $clog2(W);
    localparam int BW   = $clog2(H);
    localparam logic [CNTW-1:0] CNT_LAST  = CNTW'(W - 1);
    localparam logic [BW-1:0]   BCNT_LAST = BW'(H - 1);

    typedef struct packed {
        logic [CNTW-1:0] cnt;
        logic [BW-1:0]   bcnt;
        logic            half;
        logic [H-1:0]    hold;
        logic            armed;
        logic [CW-1:0]   rem;
        logic [W-1:0]    word;
        logic            valid;
    } fst_t;

    fst_t         q, d;
    logic         emit;
    logic [W-1:0] emit_word;
    logic [H-1:0] byte_v;

    always_comb begin
        d         = q;
        d.valid   = 1'b0;
        blk_done  = 1'b0;
        emit      = 1'b0;
        emit_word = sh_next;
        byte_v    = sh_next[H-1:0];
        if (restart) begin
            d.cnt   = '0;
            d.bcnt  = '0;
            d.half  = 1'b0;
            d.armed = !gate_en;
            d.rem   = count_load;
        end else if (ev.step) begin
            if (ev.match) begin
                d.cnt   = '0;
                d.bcnt  = '0;
                d.half  = 1'b0;
                d.armed = 1'b1;
            end else if (!msb_mode) begin
                if (q.cnt == CNT_LAST) begin
                    d.cnt = '0;
                    emit  = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end else begin
                if (q.bcnt == '0) begin
                    if (ev.bit_val) begin
                        d.bcnt = BW'(1);
                    end
                end else if (q.bcnt == BCNT_LAST) begin
                    d.bcnt = '0;
                    if (!q.half) begin
                        d.hold = byte_v;
                        d.half = 1'b1;
                    end else begin
                        d.half    = 1'b0;
                        emit      = 1'b1;
                        emit_word = {q.hold, byte_v};
                    end
                end else begin
                    d.bcnt = q.bcnt + 1'b1;
                end
            end
            if (emit && q.armed && (q.rem != '0)) begin
                d.valid  = 1'b1;
                d.word   = emit_word;
                d.rem    = q.rem - 1'b1;
                blk_done = (q.rem == CW'(1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign word_o  = q.word;
    assign valid_o = q.valid;
endmodule

// File: rtl/disk_word_sync.sv
module disk_word_sync
    import dws_pkg::*;
#(
    parameter int           W        = 16,
    parameter int           CW       = 16,
    parameter logic [W-1:0] SYNC_RST = 16'h4489
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          read_en_i,
    input  logic          gate_en_i,
    input  logic          msb_mode_i,
    input  logic          bit_i,
    input  logic          bit_en_i,
    input  logic          sync_we_i,
    input  logic [W-1:0]  sync_wdata_i,
    input  logic [CW-1:0] word_count_i,
    input  logic          sync_clr_i,
    input  logic          blk_clr_i,
    output logic [W-1:0]  word_o,
    output logic          word_valid_o,
    output logic          sync_irq_o,
    output logic          blk_irq_o
);
    typedef struct packed {
        logic rd;
        logic sirq;
        logic birq;
    } tst_t;

    tst_t         q, d;
    logic         restart;
    logic         step;
    logic         match_w;
    logic         blk_done_w;
    logic [W-1:0] sh_next_w;
    dws_bit_t     ev;

    assign restart = read_en_i && !q.rd;
    assign step    = bit_en_i && read_en_i && q.rd;

    dws_matcher #(.W(W), .SYNC_RST(SYNC_RST)) u_matcher (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .step       (step),
        .bit_i      (bit_i),
        .sync_we    (sync_we_i),
        .sync_wdata (sync_wdata_i),
        .sh_next    (sh_next_w),
        .match      (match_w)
    );

    always_comb begin
        ev.step    = step;
        ev.bit_val = bit_i;
        ev.match   = match_w;
    end

    dws_framer #(.W(W), .CW(CW)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .gate_en    (gate_en_i),
        .msb_mode   (msb_mode_i),
        .count_load (word_count_i),
        .ev         (ev),
        .sh_next    (sh_next_w),
        .word_o     (word_o),
        .valid_o    (word_valid_o),
        .blk_done   (blk_done_w)
    );

    always_comb begin
        d      = q;
        d.rd   = read_en_i;
        d.sirq = (q.sirq && !sync_clr_i) || match_w;
        d.birq = (q.birq && !blk_clr_i) || blk_done_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sync_irq_o = q.sirq;
    assign blk_irq_o  = q.birq;
endmodule

// File: rtl/dws_checker.sv
module dws_checker (
    input logic clk,
    input logic rst_n,
    input logic read_en_i,
    input logic bit_en_i,
    input logic match,
    input logic blk_done,
    input logic sync_clr_i,
    input logic blk_clr_i,
    input logic word_valid_o,
    input logic sync_irq_o,
    input logic blk_irq_o
);
    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o);

    a_r8_valid_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> $past(bit_en_i));

    a_r3_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> sync_irq_o);

    a_r3_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_clr_i && !match) |=> !sync_irq_o);

    a_r9_blk_flag: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> (blk_irq_o && word_valid_o));

    a_r9_blk_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_clr_i && !blk_done) |=> !blk_irq_o);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !read_en_i |=> (!word_valid_o && !$rose(sync_irq_o)));
endmodule

bind disk_word_sync dws_checker u_dws_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .read_en_i    (read_en_i),
    .bit_en_i     (bit_en_i),
    .match        (match_w),
    .blk_done     (blk_done_w),
    .sync_clr_i   (sync_clr_i),
    .blk_clr_i    (blk_clr_i),
    .word_valid_o (word_valid_o),
    .sync_irq_o   (sync_irq_o),
    .blk_irq_o    (blk_irq_o)
);

// File: tb/disk_word_sync_bench.sv
module disk_word_sync_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        read_en = 0, gate_en = 0, msb_mode = 0, bit_in = 0, bit_en = 0;
    logic        sync_we = 0, sync_clr = 0, blk_clr = 0;
    logic [15:0] sync_wdata = '0, word_count = '0;
    logic [15:0] word_o;
    logic        word_valid_o, sync_irq_o, blk_irq_o;

    int n_chk = 0, n_bad = 0;
    int n_words = 0;

    always #2.5 clk = ~clk;

    disk_word_sync u_disk_word_sync (
        .clk(clk), .rst_n(rst_n), .read_en_i(read_en), .gate_en_i(gate_en),
        .msb_mode_i(msb_mode), .bit_i(bit_in), .bit_en_i(bit_en),
        .sync_we_i(sync_we), .sync_wdata_i(sync_wdata), .word_count_i(word_count),
        .sync_clr_i(sync_clr), .blk_clr_i(blk_clr), .word_o(word_o),
        .word_valid_o(word_valid_o), .sync_irq_o(sync_irq_o), .blk_irq_o(blk_irq_o)
    );

    // reference state, derived from the requirements
    logic [15:0] m_sh, m_sync = 16'h4489, m_w;
    int          m_fill, m_cnt, m_bcnt, m_rem;
    logic        m_half, m_armed, m_sflag, m_bflag, m_active, m_v, m_msb;
    logic [7:0]  m_hold;

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_restart(input logic g, input logic msb, input int cnt);
        m_sh = '0; m_fill = 0; m_cnt = 0; m_bcnt = 0; m_half = 0;
        m_armed = !g; m_rem = cnt; m_msb = msb; m_active = 1;
    endtask

    task automatic model_bit(input logic b);
        logic [15:0] nsh;
        logic        emit, hit;
        logic [15:0] ew;
        m_v = 0; emit = 0; ew = '0;
        if (!m_active) return;
        nsh = {m_sh[14:0], b};
        hit = (m_fill >= 15) && (nsh == m_sync);
        if (m_fill < 16) m_fill++;
        if (hit) begin
            m_sflag = 1; m_cnt = 0; m_bcnt = 0; m_half = 0; m_armed = 1;
        end else if (!m_msb) begin
            if (m_cnt == 15) begin m_cnt = 0; emit = 1; ew = nsh; end
            else m_cnt++;
        end else begin
            if (m_bcnt == 0) begin
                if (b) m_bcnt = 1;
            end else if (m_bcnt == 7) begin
                m_bcnt = 0;
                if (!m_half) begin m_hold = nsh[7:0]; m_half = 1; end
                else begin m_half = 0; emit = 1; ew = {m_hold, nsh[7:0]}; end
            end else m_bcnt++;
        end
        if (emit && m_armed && m_rem > 0) begin
            m_v = 1; m_w = ew; m_rem--;
            if (m_rem == 0) m_bflag = 1;
        end
        m_sh = nsh;
    endtask

    task automatic send_bit(input logic b, input string tag);
        @(negedge clk); bit_en = 1; bit_in = b;
        model_bit(b);
        @(negedge clk); bit_en = 0; bit_in = 0;
        check(tag, "word_valid", word_valid_o, m_v);
        if (m_v) begin
            check(tag, "word", word_o, m_w);
            n_words++;
        end
        check("R3", "sync_irq", sync_irq_o, m_sflag);
        check("R9", "blk_irq", blk_irq_o, m_bflag);
        repeat ($urandom_range(0, 2)) begin
            @(negedge clk);
            check("R8", "valid idle", word_valid_o, 1'b0);
        end
    endtask

    task automatic send_word(input logic [15:0] w, input string tag);
        for (int i = 15; i >= 0; i--) send_bit(w[i], tag);
    endtask

    task automatic send_rand(input int n, input string tag);
        for (int i = 0; i < n; i++) send_bit(1'($urandom_range(0, 1)), tag);
    endtask

    task automatic start_read(input logic g, input logic msb, input int cnt);
        @(negedge clk); read_en = 0;
        @(negedge clk);
        gate_en = g; msb_mode = msb; word_count = 16'(cnt); read_en = 1;
        bit_en = 1; bit_in = 1;          // R11: strobe in the starting cycle is ignored
        model_restart(g, msb, cnt);
        @(negedge clk); bit_en = 0;
        check("R11", "valid at start", word_valid_o, 1'b0);
    endtask

    task automatic stop_read();
        @(negedge clk); read_en = 0; m_active = 0;
    endtask

    task automatic write_sync(input logic [15:0] v);
        @(negedge clk); sync_we = 1; sync_wdata = v; m_sync = v;
        @(negedge clk); sync_we = 0;
    endtask

    task automatic clear_flags(input logic s, input logic bk);
        @(negedge clk); sync_clr = s; blk_clr = bk;
        if (s) m_sflag = 0;
        if (bk) m_bflag = 0;
        @(negedge clk); sync_clr = 0; blk_clr = 0;
        check("R3", "sync after clear", sync_irq_o, m_sflag);
        check("R9", "blk after clear", blk_irq_o, m_bflag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int seed_dummy;
        int w0;
        seed_dummy = $urandom(32'h5eed);
        m_sflag = 0; m_bflag = 0; m_active = 0; m_v = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1", "valid after reset", word_valid_o, 1'b0);
        check("R1", "sync flag after reset", sync_irq_o, 1'b0);
        check("R1", "blk flag after reset", blk_irq_o, 1'b0);

        // R6: ungated framing every 16 bits
        start_read(0, 0, 200);
        w0 = n_words;
        send_word(16'h1234, "R6");
        send_word(16'hBEEF, "R6");
        send_rand(64, "R6");
        check("R6", "word count ungated", n_words - w0, 6);
        stop_read();

        // R4, R1 default sync, R5 resync
        start_read(1, 0, 200);
        w0 = n_words;
        send_word(16'h0F0F, "R4");
        send_word(16'h5555, "R4");
        check("R4", "no word before sync", n_words - w0, 0);
        send_word(16'h4489, "R4");
        check("R1", "default sync value matched", sync_irq_o, 1'b1);
        send_word(16'hCAFE, "R4");
        send_rand(37, "R4");
        send_word(16'h4489, "R5");
        send_word(16'hA5C3, "R5");
        send_rand(20, "R5");
        stop_read();

        // R3: flag with gating off
        clear_flags(1, 0);
        start_read(0, 0, 200);
        send_rand(5, "R3");
        send_word(16'h4489, "R3");
        check("R3", "flag with gating off", sync_irq_o, 1'b1);
        send_rand(20, "R3");
        stop_read();

        // R2 overlap, R10 sync write
        clear_flags(1, 0);
        write_sync(16'hAAAA);
        start_read(1, 0, 100);
        for (int i = 0; i < 9; i++) begin send_bit(1, "R2"); send_bit(0, "R2"); end
        check("R10", "written sync matched", sync_irq_o, 1'b1);
        clear_flags(1, 0);
        send_bit(1, "R2");
        send_bit(0, "R2");
        check("R2", "overlapping match", sync_irq_o, 1'b1);
        send_rand(40, "R2");
        stop_read();
        write_sync(16'h4489);

        // R7: byte mode
        clear_flags(1, 0);
        start_read(0, 1, 50);
        w0 = n_words;
        for (int i = 0; i < 30; i++) begin
            logic [7:0] bv;
            bv = 8'($urandom_range(0, 255)) | 8'h80;
            repeat ($urandom_range(0, 3)) send_bit(0, "R7");
            for (int k = 7; k >= 0; k--) send_bit(bv[k], "R7");
        end
        check("R7", "byte pairs delivered", (n_words - w0) > 10, 1'b1);
        stop_read();

        // R9: word count exhaustion
        clear_flags(1, 1);
        start_read(0, 0, 3);
        w0 = n_words;
        send_rand(80, "R9");
        check("R9", "words limited by count", n_words - w0, 3);
        check("R9", "blk flag set", blk_irq_o, 1'b1);
        clear_flags(0, 1);
        stop_read();

        // R11: bits with read disabled
        clear_flags(1, 1);
        send_word(16'h4489, "R11");
        check("R11", "no flag while idle", sync_irq_o, 1'b0);

        // mixed random reads
        for (int r = 0; r < 8; r++) begin
            start_read(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom_range(0, 8));
            for (int s = 0; s < 12; s++) begin
                if ($urandom_range(0, 3) == 0) send_word(16'h4489, "R5");
                else send_rand($urandom_range(1, 24), "R8");
                if ($urandom_range(0, 5) == 0) clear_flags(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            end
            stop_read();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule